// File: doc/BRIEF.md
# PIPE Lane Control Sequencer

This block sits on the controller side of a PIPE connection to one SerDes lane and orders the handshakes that the lane needs. After reset it keeps the lane's PCS in reset until the PHY reports that the lane transfer path is ready. It then waits for the PHY to confirm a stable PCLK. Once that completes, it accepts commands from a small command port. A command is either a receiver-detect request or a change to a new link rate.

A rate change follows a fixed order. The new rate code is driven first. The PHY then grants the change. The block answers with the PCLK-change acknowledge and holds it until the PHY signals completion. Finally the block waits for the receiver CDR to lock again before it reports the link ready. Every wait for the PHY is bounded by a programmable timeout. While the link is expected to be locked, a drop in CDR lock is reported as a receiver fault together with a request to reset the receiver.

Power state is held at P0 (powerdown code 00) and receiver terminations are always present. All logic runs on the single PCLK-domain clock and uses a synchronous, active-high reset.

Top module: `pipe_lane_seq`

## Requirements
- R1: While `rst` is high, the block resets to these output values: `mac_pcs_rst_n`=0, `mac_rate`=000 (first generation), `mac_detect_rx`=0, `mac_pclk_ack`=0, `stat_rate`=000, `link_ready`=0, `rx_fault`=0 and `busy_reject`=0.
- R2: `mac_pcs_rst_n` stays low until a clock edge samples `phy_xfer_en` high. It is high after that edge and stays high until the next reset.
- R3: After the PCS reset is released, no command is accepted until a `phy_status` pulse confirms a stable PCLK. A command that arrives before that point is rejected.
- R4: A detect command (`cmd_valid`=1, `cmd_detect`=1) accepted in idle raises `mac_detect_rx` one cycle later. `mac_detect_rx` stays high until an edge samples `phy_status` high and is low after that edge. After that same edge, `det_done` pulses for one cycle and `det_found` equals the `phy_rx_status` value sampled at that edge.
- R5: A rate command (`cmd_valid`=1, `cmd_detect`=0) accepted in idle drives `cmd_rate` on `mac_rate` one cycle later. `mac_pclk_ack` rises only after an edge that samples `phy_rate_ok` high. `mac_pclk_ack` falls after an edge that samples `phy_status` high, and `stat_rate` takes the new rate after that same edge.
- R6: The rate codes are 000 to 100, for generations one to five. A rate command with a code above 100 is ignored: `mac_rate` is unchanged, the block stays idle, and `mac_rate` never carries a code above 100.
- R7: A command that arrives while a detect or a rate change is in progress is rejected. `busy_reject` pulses high for one cycle after the edge that sampled the command, and the command has no effect.
- R8: If an awaited event does not arrive, the block times out on the `cfg_timeout`-th clock edge after it entered the wait. On timeout, `tmo_err` pulses for one cycle, `mac_detect_rx` and `mac_pclk_ack` drop, `mac_rate` returns to `stat_rate`, and the block is idle again.
- R9: In idle, or during a detect, a fall of `phy_cdr_lock` sets `rx_fault` and pulses `rx_reset_req` for one cycle, both after the edge that sees lock low. `rx_fault` stays set until a rate command is accepted.
- R10: A CDR lock loss during a rate change raises no fault. During a rate change, `link_ready` is low until `phy_cdr_lock` is seen high again, and `link_ready` is high only in idle while `phy_cdr_lock` is high.
- R11: `rx_valid` follows `phy_cdr_data_lock` while the PCS reset is released, and is low while the PCS reset is held.
- R12: `mac_rx_term` is always 1 and `mac_powerdown` is always 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCLK-domain clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_detect | input | 1 | 1 = receiver detect, 0 = rate change |
| cmd_rate | input | 3 | Target rate code for a rate command |
| cfg_timeout | input | TMO_W | Wait limit in cycles (1 or more) |
| phy_xfer_en | input | 1 | PHY lane transfer path ready |
| phy_status | input | 1 | PHY operation-complete pulse |
| phy_rx_status | input | 1 | Receiver-present result |
| phy_rate_ok | input | 1 | PHY permits the rate/clock change |
| phy_cdr_lock | input | 1 | CDR frequency lock |
| phy_cdr_data_lock | input | 1 | CDR locked to data |
| mac_rate | output | 3 | Rate code driven to the PHY |
| mac_detect_rx | output | 1 | Receiver-detect request |
| mac_powerdown | output | 2 | Power state (P0) |
| mac_rx_term | output | 1 | Receiver terminations present |
| mac_pclk_ack | output | 1 | PCLK change complete acknowledge |
| mac_pcs_rst_n | output | 1 | Active-low lane PCS reset |
| stat_rate | output | 3 | Rate in effect after last completed change |
| det_done | output | 1 | One-cycle detect completion pulse |
| det_found | output | 1 | Receiver seen in last detect |
| link_ready | output | 1 | Idle with CDR locked |
| rx_fault | output | 1 | Sticky CDR lock-loss fault |
| rx_reset_req | output | 1 | One-cycle receiver reset request |
| busy_reject | output | 1 | One-cycle command rejection pulse |
| tmo_err | output | 1 | One-cycle timeout pulse |
| rx_valid | output | 1 | Receive data valid |

## Verification
Every registered result (the PCS reset, detect request, acknowledge, rate codes, and the done, reject, timeout and fault pulses) is due one clock after the edge that samples its cause. `link_ready` and `rx_valid` follow their inputs in the same cycle. The bench changes inputs 1 ns after a rising edge and reads outputs at that same point, so each read shows exactly the edges already taken. Timeout checks count edges from the accepting edge and expect `tmo_err` after the `cfg_timeout`-th edge and not before. Pulse outputs are checked high in their due cycle and low in the cycle after.

// File: rtl/pls_pkg.sv
package pls_pkg;

    localparam logic [2:0] RATE_MAX = 3'd4;
    localparam logic [1:0] PD_P0    = 2'b00;

    typedef enum logic [2:0] {
        ST_RST,
        ST_PCLK,
        ST_IDLE,
        ST_DET,
        ST_RC_REQ,
        ST_RC_ACK,
        ST_RELOCK
    } seq_st_e;

    typedef enum logic {
        OP_RATE   = 1'b0,
        OP_DETECT = 1'b1
    } cmd_op_e;

    typedef struct packed {
        logic       valid;
        cmd_op_e    op;
        logic [2:0] rate;
    } lane_cmd_t;

    function automatic logic rate_legal(input logic [2:0] r);
        return r <= RATE_MAX;
    endfunction

    function automatic logic lock_watched(input seq_st_e s);
        return (s == ST_IDLE) || (s == ST_DET);
    endfunction

endpackage

// File: rtl/pls_rst_gate.sv
module pls_rst_gate (
    input  logic clk,
    input  logic rst,
    input  logic xfer_en,
    output logic pcs_rst_n
);
    always_ff @(posedge clk) begin
        if (rst)
            pcs_rst_n <= 1'b0;
        else if (xfer_en)
            pcs_rst_n <= 1'b1;
    end
endmodule

// File: rtl/pls_lock_mon.sv
module pls_lock_mon (
    input  logic clk,
    input  logic rst,
    input  logic cdr_lock,
    input  logic chk_en,
    input  logic clr,
    output logic fault,
    output logic reset_req
);
    logic lock_q;
    logic fall;

    assign fall = lock_q & ~cdr_lock & chk_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_q    <= 1'b0;
            fault     <= 1'b0;
            reset_req <= 1'b0;
        end else begin
            lock_q    <= cdr_lock;
            reset_req <= fall;
            if (clr)
                fault <= 1'b0;
            else if (fall)
                fault <= 1'b1;
        end
    end
endmodule

// File: rtl/pls_ctrl_fsm.sv
module pls_ctrl_fsm
    import pls_pkg::*;
#(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pcs_released,
    input  lane_cmd_t        cmd,
    input  logic [TMO_W-1:0] tmo_limit,
    input  logic             phy_status,
    input  logic             rx_status,
    input  logic             rate_ok,
    input  logic             cdr_lock,
    output seq_st_e          st,
    output logic [2:0]       rate_q,
    output logic [2:0]       rate_cur,
    output logic             detect_rx,
    output logic             pclk_ack,
    output logic             det_done,
    output logic             det_found,
    output logic             busy_rej,
    output logic             tmo_err,
    output logic             rate_taken
);
    logic [TMO_W-1:0] cnt;
    logic             tmo_hit;

    assign tmo_hit    = (cnt == tmo_limit - 1'b1);
    assign rate_taken = (st == ST_IDLE) && cmd.valid && (cmd.op == OP_RATE)
                        && rate_legal(cmd.rate);

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_RST;
            rate_q    <= 3'd0;
            rate_cur  <= 3'd0;
            detect_rx <= 1'b0;
            pclk_ack  <= 1'b0;
            det_done  <= 1'b0;
            det_found <= 1'b0;
            busy_rej  <= 1'b0;
            tmo_err   <= 1'b0;
            cnt       <= '0;
        end else begin
            det_done <= 1'b0;
            busy_rej <= cmd.valid && (st != ST_IDLE);
            tmo_err  <= 1'b0;
            cnt      <= cnt + 1'b1;
            unique case (st)
                ST_RST: begin
                    cnt <= '0;
                    if (pcs_released) st <= ST_PCLK;
                end
                ST_PCLK: begin
                    if (phy_status) begin
                        st <= ST_IDLE;
                    end else if (tmo_hit) begin
                        tmo_err <= 1'b1;
                        st      <= ST_IDLE;
                    end
                end
                ST_IDLE: begin
                    cnt <= '0;
                    if (cmd.valid && cmd.op == OP_DETECT) begin
                        detect_rx <= 1'b1;
                        st        <= ST_DET;
                    end else if (rate_taken) begin
                        rate_q <= cmd.rate;
                        st     <= ST_RC_REQ;
                    end
                end
                ST_DET: begin
                    if (phy_status) begin
                        detect_rx <= 1'b0;
                        det_done  <= 1'b1;
                        det_found <= rx_status;
                        st        <= ST_IDLE;
                    end else if (tmo_hit) begin
                        detect_rx <= 1'b0;
                        tmo_err   <= 1'b1;
                        st        <= ST_IDLE;
                    end
                end
                ST_RC_REQ: begin
                    if (rate_ok) begin
                        pclk_ack <= 1'b1;
                        cnt      <= '0;
                        st       <= ST_RC_ACK;
                    end else if (tmo_hit) begin
                        rate_q  <= rate_cur;
                        tmo_err <= 1'b1;
                        st      <= ST_IDLE;
                    end
                end
                ST_RC_ACK: begin
                    if (phy_status) begin
                        pclk_ack <= 1'b0;
                        rate_cur <= rate_q;
                        cnt      <= '0;
                        st       <= ST_RELOCK;
                    end else if (tmo_hit) begin
                        pclk_ack <= 1'b0;
                        rate_q   <= rate_cur;
                        tmo_err  <= 1'b1;
                        st       <= ST_IDLE;
                    end
                end
                ST_RELOCK: begin
                    if (cdr_lock) begin
                        st <= ST_IDLE;
                    end else if (tmo_hit) begin
                        tmo_err <= 1'b1;
                        st      <= ST_IDLE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pipe_lane_seq.sv
module pipe_lane_seq
    import pls_pkg::*;
#(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  logic             cmd_detect,
    input  logic [2:0]       cmd_rate,
    input  logic [TMO_W-1:0] cfg_timeout,
    input  logic             phy_xfer_en,
    input  logic             phy_status,
    input  logic             phy_rx_status,
    input  logic             phy_rate_ok,
    input  logic             phy_cdr_lock,
    input  logic             phy_cdr_data_lock,
    output logic [2:0]       mac_rate,
    output logic             mac_detect_rx,
    output logic [1:0]       mac_powerdown,
    output logic             mac_rx_term,
    output logic             mac_pclk_ack,
    output logic             mac_pcs_rst_n,
    output logic [2:0]       stat_rate,
    output logic             det_done,
    output logic             det_found,
    output logic             link_ready,
    output logic             rx_fault,
    output logic             rx_reset_req,
    output logic             busy_reject,
    output logic             tmo_err,
    output logic             rx_valid
);
    lane_cmd_t cmd;
    seq_st_e   st;
    logic      rate_taken;

    assign cmd.valid = cmd_valid;
    assign cmd.op    = cmd_op_e'(cmd_detect);
    assign cmd.rate  = cmd_rate;

    pls_rst_gate u_rst (
        .clk       (clk),
        .rst       (rst),
        .xfer_en   (phy_xfer_en),
        .pcs_rst_n (mac_pcs_rst_n)
    );

    pls_ctrl_fsm #(.TMO_W(TMO_W)) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .pcs_released (mac_pcs_rst_n),
        .cmd          (cmd),
        .tmo_limit    (cfg_timeout),
        .phy_status   (phy_status),
        .rx_status    (phy_rx_status),
        .rate_ok      (phy_rate_ok),
        .cdr_lock     (phy_cdr_lock),
        .st           (st),
        .rate_q       (mac_rate),
        .rate_cur     (stat_rate),
        .detect_rx    (mac_detect_rx),
        .pclk_ack     (mac_pclk_ack),
        .det_done     (det_done),
        .det_found    (det_found),
        .busy_rej     (busy_reject),
        .tmo_err      (tmo_err),
        .rate_taken   (rate_taken)
    );

    pls_lock_mon u_lock (
        .clk       (clk),
        .rst       (rst),
        .cdr_lock  (phy_cdr_lock),
        .chk_en    (lock_watched(st)),
        .clr       (rate_taken),
        .fault     (rx_fault),
        .reset_req (rx_reset_req)
    );

    assign link_ready    = (st == ST_IDLE) && phy_cdr_lock;
    assign rx_valid      = phy_cdr_data_lock && mac_pcs_rst_n;
    assign mac_powerdown = PD_P0;
    assign mac_rx_term   = 1'b1;
endmodule

// File: rtl/pipe_lane_seq_chk.sv
module pipe_lane_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       phy_xfer_en,
    input logic       phy_status,
    input logic       phy_rate_ok,
    input logic [2:0] mac_rate,
    input logic       mac_detect_rx,
    input logic       mac_pclk_ack,
    input logic       mac_pcs_rst_n,
    input logic       link_ready,
    input logic       rx_fault,
    input logic       rx_reset_req,
    input logic       tmo_err
);
    a_r2_release_after_xfer: assert property (@(posedge clk) disable iff (rst)
        $rose(mac_pcs_rst_n) |-> $past(phy_xfer_en));

    a_r2_release_sticky: assert property (@(posedge clk) disable iff (rst)
        mac_pcs_rst_n |=> mac_pcs_rst_n);

    a_r4_detect_drops: assert property (@(posedge clk) disable iff (rst)
        (mac_detect_rx && phy_status) |=> !mac_detect_rx);

    a_r5_ack_after_ok: assert property (@(posedge clk) disable iff (rst)
        $rose(mac_pclk_ack) |-> $past(phy_rate_ok));

    a_r5_ack_release: assert property (@(posedge clk) disable iff (rst)
        $fell(mac_pclk_ack) |-> ($past(phy_status) || tmo_err));

    a_r6_rate_legal: assert property (@(posedge clk) disable iff (rst)
        mac_rate <= 3'd4);

    a_r9_req_implies_fault: assert property (@(posedge clk) disable iff (rst)
        rx_reset_req |-> rx_fault);

    a_r10_not_ready_in_change: assert property (@(posedge clk) disable iff (rst)
        mac_pclk_ack |-> !link_ready);
endmodule

bind pipe_lane_seq pipe_lane_seq_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .phy_xfer_en   (phy_xfer_en),
    .phy_status    (phy_status),
    .phy_rate_ok   (phy_rate_ok),
    .mac_rate      (mac_rate),
    .mac_detect_rx (mac_detect_rx),
    .mac_pclk_ack  (mac_pclk_ack),
    .mac_pcs_rst_n (mac_pcs_rst_n),
    .link_ready    (link_ready),
    .rx_fault      (rx_fault),
    .rx_reset_req  (rx_reset_req),
    .tmo_err       (tmo_err)
);

// File: tb/tb_pipe_lane_seq.sv
module tb_pipe_lane_seq;
    localparam int TMO_W = 16;
    // {target rate[5:3], cycles before rate grant[2:0]}
    localparam logic [5:0] RC_VEC [5] = '{
        {3'd1, 3'd0}, {3'd3, 3'd2}, {3'd4, 3'd1}, {3'd2, 3'd3}, {3'd0, 3'd0}
    };

    logic clk = 1'b0;
    logic rst;
    logic cmd_valid, cmd_detect;
    logic [2:0] cmd_rate;
    logic [TMO_W-1:0] cfg_timeout;
    logic phy_xfer_en, phy_status, phy_rx_status, phy_rate_ok;
    logic phy_cdr_lock, phy_cdr_data_lock;
    logic [2:0] mac_rate, stat_rate;
    logic mac_detect_rx, mac_rx_term, mac_pclk_ack, mac_pcs_rst_n;
    logic [1:0] mac_powerdown;
    logic det_done, det_found, link_ready, rx_fault, rx_reset_req;
    logic busy_reject, tmo_err, rx_valid;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    pipe_lane_seq #(.TMO_W(TMO_W)) dut (.*);

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic send(input logic det, input logic [2:0] r);
        cmd_valid = 1'b1; cmd_detect = det; cmd_rate = r;
        step();
        cmd_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; cmd_valid = 0; cmd_detect = 0; cmd_rate = 0; cfg_timeout = 20;
        phy_xfer_en = 0; phy_status = 0; phy_rx_status = 0; phy_rate_ok = 0;
        phy_cdr_lock = 0; phy_cdr_data_lock = 1;
        repeat (3) step();
        chk("R1 pcs_rst_n", mac_pcs_rst_n, 0);
        chk("R1 rate", mac_rate, 0);
        chk("R1 detect", mac_detect_rx, 0);
        chk("R1 ack", mac_pclk_ack, 0);
        chk("R1 stat_rate", stat_rate, 0);
        chk("R1 link_ready", link_ready, 0);
        chk("R1 rx_fault", rx_fault, 0);
        chk("R1 busy", busy_reject, 0);
        chk("R12 term", mac_rx_term, 1);
        chk("R12 powerdown", mac_powerdown, 0);
        rst = 1'b0;
        repeat (3) step();
        chk("R2 held", mac_pcs_rst_n, 0);
        chk("R11 valid during pcs reset", rx_valid, 0);
        send(1'b1, 3'd0);
        chk("R3 reject before ready", busy_reject, 1);
        chk("R3 no detect", mac_detect_rx, 0);
        phy_xfer_en = 1'b1;
        step();
        chk("R2 released", mac_pcs_rst_n, 1);
        phy_xfer_en = 1'b0; phy_cdr_lock = 1'b1;
        step();
        chk("R2 sticky", mac_pcs_rst_n, 1);
        chk("R3 not ready before pclk status", link_ready, 0);
        chk("R11 valid follows data lock", rx_valid, 1);
        send(1'b1, 3'd0);
        chk("R3 reject while waiting pclk", busy_reject, 1);
        phy_status = 1'b1;
        step();
        phy_status = 1'b0;
        chk("R3 ready after pclk status", link_ready, 1);

        // detect: receiver present then absent
        for (int k = 0; k < 2; k++) begin
            send(1'b1, 3'd0);
            chk("R4 detect raised", mac_detect_rx, 1);
            step();
            chk("R4 detect held", mac_detect_rx, 1);
            chk("R4 no done yet", det_done, 0);
            phy_status = 1'b1; phy_rx_status = (k == 0);
            step();
            phy_status = 1'b0; phy_rx_status = 1'b0;
            chk("R4 detect dropped", mac_detect_rx, 0);
            chk("R4 done pulse", det_done, 1);
            chk("R4 found", det_found, (k == 0));
            step();
            chk("R4 done ends", det_done, 0);
        end

        // busy reject during detect
        send(1'b1, 3'd0);
        send(1'b0, 3'd3);
        chk("R7 busy pulse", busy_reject, 1);
        chk("R7 rate unchanged", mac_rate, 0);
        step();
        chk("R7 busy ends", busy_reject, 0);
        phy_status = 1'b1;
        step();
        phy_status = 1'b0;

        // table of rate changes
        for (int v = 0; v < 5; v++) begin
            send(1'b0, RC_VEC[v][5:3]);
            chk("R5 rate driven", mac_rate, RC_VEC[v][5:3]);
            chk("R10 not ready in change", link_ready, 0);
            phy_cdr_lock = 1'b0;
            for (int w = 0; w < int'(RC_VEC[v][2:0]); w++) begin
                step();
                chk("R5 no ack before grant", mac_pclk_ack, 0);
            end
            step();
            chk("R10 no fault during change", rx_reset_req, 0);
            phy_rate_ok = 1'b1;
            step();
            phy_rate_ok = 1'b0;
            chk("R5 ack raised", mac_pclk_ack, 1);
            phy_status = 1'b1;
            step();
            phy_status = 1'b0;
            chk("R5 ack dropped", mac_pclk_ack, 0);
            chk("R5 stat_rate", stat_rate, RC_VEC[v][5:3]);
            step();
            chk("R10 waits for lock", link_ready, 0);
            phy_cdr_lock = 1'b1;
            step();
            chk("R10 ready after lock", link_ready, 1);
            chk("R10 no fault", rx_fault, 0);
        end

        // illegal codes
        send(1'b0, 3'd5);
        chk("R6 code 5 ignored", mac_rate, 0);
        chk("R6 no reject", busy_reject, 0);
        send(1'b0, 3'd7);
        chk("R6 code 7 ignored", mac_rate, 0);
        send(1'b1, 3'd0);
        chk("R6 still idle", mac_detect_rx, 1);
        phy_status = 1'b1;
        step();
        phy_status = 1'b0;

        // timeouts
        cfg_timeout = 4;
        send(1'b0, 3'd2);
        chk("R8 rate driven", mac_rate, 2);
        for (int e = 0; e < 3; e++) begin
            step();
            chk("R8 no early timeout", tmo_err, 0);
        end
        step();
        chk("R8 rate timeout", tmo_err, 1);
        chk("R8 rate reverted", mac_rate, 0);
        chk("R8 ack low", mac_pclk_ack, 0);
        step();
        chk("R8 pulse ends", tmo_err, 0);
        chk("R8 back to idle", link_ready, 1);
        send(1'b1, 3'd0);
        repeat (3) step();
        chk("R8 detect waiting", mac_detect_rx, 1);
        step();
        chk("R8 detect timeout", tmo_err, 1);
        chk("R8 detect dropped", mac_detect_rx, 0);
        cfg_timeout = 20;

        // lock loss in idle
        phy_cdr_lock = 1'b0;
        step();
        chk("R9 fault set", rx_fault, 1);
        chk("R9 reset request", rx_reset_req, 1);
        step();
        chk("R9 request pulse ends", rx_reset_req, 0);
        chk("R9 fault sticky", rx_fault, 1);
        chk("R10 not ready without lock", link_ready, 0);
        phy_cdr_lock = 1'b1;
        step();
        chk("R9 fault held after relock", rx_fault, 1);
        send(1'b0, 3'd1);
        chk("R9 fault cleared by rate cmd", rx_fault, 0);
        phy_rate_ok = 1'b1;
        step();
        phy_rate_ok = 1'b0; phy_status = 1'b1;
        step();
        phy_status = 1'b0;
        step();
        chk("R10 relocked ready", link_ready, 1);

        phy_cdr_data_lock = 1'b0;
        step();
        chk("R11 valid low without data lock", rx_valid, 0);
        chk("R12 term held", mac_rx_term, 1);
        chk("R12 powerdown held", mac_powerdown, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule